// File: doc/BRIEF.md
# Programmable Delay Timer Bank

This block holds several independent delay timers for supply supervision logic. Supervision logic uses them to wait for supplies to settle, and also to build timeout checks. Each timer has three controls from that logic: a run level, a 4-bit duration code and a source select. It drives one done flag. While run is low the timer sits cleared. When run rises, the timer captures its code and source. It then counts time-base events until the selected length is reached, raises done, and holds done until run is dropped. The same timer can therefore be cleared and restarted under a different condition for each step of a power-up or power-down sequence.

There are two possible time bases. The first is a clock-enable tick derived from a 250 kHz oscillator, which gives one event every 4 us. The second is an external slow clock that stretches the delay to any length. The external clock is passed through a two-flop synchronizer, and only its rising edges count as events. With the default base of 8 ticks, the sixteen codes run from 32 us to about 1 s in doubling steps: code 15 gives 262144 ticks, roughly 1.05 s.

Top module: `delay_timer_bank`

## Requirements
- R1: While rst_n is low, and after it is released, every done output is 0.
- R2: The length for code k is 2^(k+BASE_LOG2) events, which is 8·2^k with the default BASE_LOG2=3. Run sampled high at edge e0 starts the timer. Events are counted at later edges where the selected source is active. Done goes to 1 at the edge that counts the last event, and it is 0 in the cycle after a start.
- R3: Done is 0 in the cycle after run is sampled low. A later start counts the full length again from zero.
- R4: Done stays 1 for as long as run stays high, whatever further events arrive.
- R5: The duration code and the source select are captured at the start edge. A change while the timer runs has no effect until the next start.
- R6: Events that arrive while run is low are not counted toward the next delay.
- R7: When the source select is 1 at start, only rising edges of ext_clk are counted and tick is ignored. A rise of ext_clk placed before edge n is counted at edge n+2. A synchronized rise lasts one cycle.
- R8: Each timer runs on its own run, code and source controls, and has no effect on any other timer.
- R9: On the internal source, a cycle counts only when tick is 1. Cycles with tick low leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal time-base enable, one cycle per oscillator period |
| ext_clk | input | 1 | External slow clock, asynchronous |
| run | input | NUM_TIMERS | Per-timer run level; low clears, rise starts |
| use_ext | input | NUM_TIMERS | Per-timer source select, 1 = external clock |
| dur_code | input | NUM_TIMERS*CODE_W | Per-timer duration code, timer i in bits [i*CODE_W +: CODE_W] |
| done | output | NUM_TIMERS | Per-timer delay-expired flag |

## Verification
Three kinds of internal fault are visible at done. A wrong captured length moves the done edge away from exactly 2^(k+BASE_LOG2) counted events after start. A count that is not cleared by a stop, or that keeps idle events, makes done come early on the next run. A wrong source choice shows up either as done rising during a burst of internal ticks while external mode is selected, or as done failing to rise two edges after the last external rise. Each of these shows within one cycle of the expected done edge, so the bench checks the cycle just before and the cycle just after the boundary for every code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Number of events for a duration code: a power of two offset by the base.
  function automatic logic [31:0] code_to_events(input logic [7:0] code,
                                                 input int unsigned base_log2);
    logic [31:0] one;
    one = 32'd1;
    return one << (32'(code) + base_log2);
  endfunction

  // Count width that holds the largest length for a code width and base.
  function automatic int unsigned count_width(input int unsigned code_w,
                                              input int unsigned base_log2);
    return base_log2 + (1 << code_w);
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned BASE_LOG2 = 3,
  parameter int unsigned CNT_W     = count_width(CODE_W, BASE_LOG2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              use_ext,
  input  logic [CODE_W-1:0] code,
  input  logic              tick,
  input  logic              ext_rise,
  output logic              start_evt,
  output logic              step_evt,
  output logic              done
);
  logic             active_q;
  logic             ext_mode_q;
  logic             done_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count_inc;
  logic [CNT_W-1:0] limit_new;
  logic [31:0]      limit_full;

  always_comb begin
    limit_full = code_to_events(8'(code), BASE_LOG2);
    limit_new  = limit_full[CNT_W-1:0];
  end

  assign start_evt = run & ~active_q;
  assign step_evt  = run & active_q & ~done_q & (ext_mode_q ? ext_rise : tick);
  assign count_inc = count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      ext_mode_q <= 1'b0;
      done_q     <= 1'b0;
      count_q    <= '0;
      limit_q    <= '0;
    end else if (!run) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      count_q  <= '0;
    end else if (start_evt) begin
      active_q   <= 1'b1;
      ext_mode_q <= use_ext;
      limit_q    <= limit_new;
      count_q    <= '0;
      done_q     <= 1'b0;
    end else if (step_evt) begin
      count_q <= count_inc;
      if (count_inc == limit_q) done_q <= 1'b1;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/delay_timer_bank.sv
module delay_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TIMERS  = 4,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned BASE_LOG2   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         ext_clk,
  input  logic [NUM_TIMERS-1:0]        run,
  input  logic [NUM_TIMERS-1:0]        use_ext,
  input  logic [NUM_TIMERS*CODE_W-1:0] dur_code,
  output logic [NUM_TIMERS-1:0]        done
);
  localparam int unsigned CNT_W = count_width(CODE_W, BASE_LOG2);

  logic                  ext_rise;
  logic [NUM_TIMERS-1:0] start_evt;
  logic [NUM_TIMERS-1:0] step_evt;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_clk),
    .rise     (ext_rise)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
    tmr_channel #(
      .CODE_W    (CODE_W),
      .BASE_LOG2 (BASE_LOG2),
      .CNT_W     (CNT_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run[i]),
      .use_ext   (use_ext[i]),
      .code      (dur_code[i*CODE_W +: CODE_W]),
      .tick      (tick),
      .ext_rise  (ext_rise),
      .start_evt (start_evt[i]),
      .step_evt  (step_evt[i]),
      .done      (done[i])
    );
  end
endmodule

// File: rtl/delay_timer_bank_chk.sv
module delay_timer_bank_chk #(
  parameter int unsigned NUM_TIMERS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TIMERS-1:0] run,
  input logic [NUM_TIMERS-1:0] done,
  input logic [NUM_TIMERS-1:0] start_evt,
  input logic [NUM_TIMERS-1:0] step_evt,
  input logic                  ext_rise
);
  // R7
  ext_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_a
    // R3
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |=> !done[i]);
    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] && run[i]) |=> done[i]);
    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt[i] |=> !done[i]);
    // R2
    rise_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[i]) |-> $past(step_evt[i]));
    // R4
    no_step_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |-> !step_evt[i]);
  end
endmodule

bind delay_timer_bank delay_timer_bank_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .done      (done),
  .start_evt (start_evt),
  .step_evt  (step_evt),
  .ext_rise  (ext_rise)
);

// File: tb/delay_timer_bank_test.sv
`timescale 1ns/1ps
module delay_timer_bank_test;
  localparam int NT = 4;
  localparam int CW = 4;
  localparam int BL = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic ext_clk = 1'b0;
  logic [NT-1:0] run = '0;
  logic [NT-1:0] use_ext = '0;
  logic [NT*CW-1:0] dur_code = '0;
  logic [NT-1:0] done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  delay_timer_bank #(.NUM_TIMERS(NT), .CODE_W(CW), .BASE_LOG2(BL)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_clk(ext_clk),
    .run(run), .use_ext(use_ext), .dur_code(dur_code), .done(done)
  );

  function automatic int span(input int k);
    return 1 << (k + BL);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_code(input int ch, input int k);
    dur_code[ch*CW +: CW] = CW'(k);
  endtask

  task automatic stop_all();
    run = '0;
    cyc(2);
  endtask

  // R2: internal source, tick always high; done at edge count N+1 from start
  task automatic sweep_code(input int k);
    int n;
    n = span(k);
    tick = 1'b1;
    set_code(0, k);
    run[0] = 1'b1;
    cyc(n);
    chk("R2 before end", int'(done[0]), 0);
    cyc(1);
    chk("R2 at end", int'(done[0]), 1);
    stop_all();
  endtask

  task automatic pulse_ticks(input int n, input int gap);
    for (int p = 0; p < n; p++) begin
      tick = 1'b1;
      cyc(1);
      tick = 1'b0;
      cyc(gap);
    end
  endtask

  task automatic ext_rises(input int n);
    for (int p = 0; p < n; p++) begin
      ext_clk = 1'b1;
      cyc(4);
      ext_clk = 1'b0;
      cyc(4);
    end
  endtask

  initial begin
    cyc(3);
    chk("R1 in reset", int'(done), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after reset", int'(done), 0);

    for (int k = 0; k < 16; k++) sweep_code(k);

    // R9: gapped ticks
    tick = 1'b0;
    set_code(0, 2);
    run[0] = 1'b1;
    cyc(1);
    pulse_ticks(3, 3);
    chk("R9 three of four ticks", int'(done[0]), 0);
    pulse_ticks(1, 0);
    chk("R9 fourth tick", int'(done[0]), 1);

    // R4: done holds under more ticks
    tick = 1'b1;
    cyc(20);
    chk("R4 hold", int'(done[0]), 1);

    // R3: stop clears, restart counts full length
    run[0] = 1'b0;
    cyc(1);
    chk("R3 stop clears", int'(done[0]), 0);
    set_code(0, 3);
    run[0] = 1'b1;
    cyc(5);
    run[0] = 1'b0;
    cyc(1);
    chk("R3 aborted run", int'(done[0]), 0);
    run[0] = 1'b1;
    cyc(8);
    chk("R3 restart before end", int'(done[0]), 0);
    cyc(1);
    chk("R3 restart at end", int'(done[0]), 1);
    stop_all();

    // R6: ticks while idle ignored
    tick = 1'b1;
    cyc(40);
    set_code(0, 3);
    run[0] = 1'b1;
    cyc(8);
    chk("R6 idle ticks ignored", int'(done[0]), 0);
    cyc(1);
    chk("R6 full length", int'(done[0]), 1);
    stop_all();

    // R5: code change mid-run has no effect until next start
    set_code(0, 2);
    run[0] = 1'b1;
    cyc(1);
    set_code(0, 5);
    cyc(3);
    chk("R5 old length before end", int'(done[0]), 0);
    cyc(1);
    chk("R5 old length kept", int'(done[0]), 1);
    stop_all();
    run[0] = 1'b1;
    cyc(32);
    chk("R5 new length before end", int'(done[0]), 0);
    cyc(1);
    chk("R5 new length at end", int'(done[0]), 1);
    stop_all();

    // R7: external source, ticks ignored
    tick = 1'b1;
    ext_clk = 1'b0;
    cyc(4);
    set_code(0, 1);
    use_ext[0] = 1'b1;
    run[0] = 1'b1;
    cyc(6);
    chk("R7 ticks ignored", int'(done[0]), 0);
    use_ext[0] = 1'b0;
    ext_rises(1);
    chk("R7 one rise", int'(done[0]), 0);
    ext_clk = 1'b1;
    cyc(2);
    chk("R7 rise latency", int'(done[0]), 0);
    cyc(1);
    chk("R7 second rise counted", int'(done[0]), 1);
    ext_clk = 1'b0;
    cyc(4);
    stop_all();
    // R5: source captured at start, internal this time despite later change
    set_code(0, 2);
    run[0] = 1'b1;
    cyc(1);
    use_ext[0] = 1'b1;
    cyc(3);
    chk("R5 source kept before end", int'(done[0]), 0);
    cyc(1);
    chk("R5 source kept at end", int'(done[0]), 1);
    use_ext[0] = 1'b0;
    stop_all();

    // R8: independent timers
    tick = 1'b1;
    set_code(1, 3);
    set_code(2, 4);
    run[1] = 1'b1;
    run[2] = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      cyc(1);
      chk("R8 timer1", int'(done[1]), (i >= 9) ? 1 : 0);
      chk("R8 timer2", int'(done[2]), (i >= 17) ? 1 : 0);
      chk("R8 idle timers", int'({done[3], done[0]}), 0);
    end
    run[1] = 1'b0;
    cyc(1);
    chk("R8 stop one only", int'(done[2:1]), 2);
    stop_all();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule